// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a scratchpad that is split into 32 word-wide banks and serves one warp-wide access at a time. A request carries one word address per lane, an active-lane mask, a load/store flag and one write word per lane. The block maps every lane onto a bank. It groups lanes that touch the same word of the same bank, because one bank access serves all of them. Lanes that need different words of one bank are spread over successive passes. All banks work in parallel in every pass.

The number of passes therefore equals the largest number of distinct words that any single bank must supply. The block reports this figure as the conflict degree when the access finishes. Load data for every lane is presented together with a one-cycle completion pulse. The bank arrays are held inside the block as small synchronous RAMs, so a store followed by a load of the same words returns the stored data.

Top module: `spad_conflict_arbiter`

## Requirements
- R1: A lane's bank is its word address modulo 32 (the low 5 address bits) and its row inside the bank is the remaining upper bits. Each of the 1024 word addresses holds its own 32-bit word: a store followed by a load of the same address returns the stored word.
- R2: When a load completes, every active lane's slot of `rsp_rdata` (bits lane*32 upward) holds the word at that lane's address. Inactive lanes read zero, and every lane reads zero after a store.
- R3: Lanes at a word stride of 1 fall in 32 different banks and finish in a single pass (degree 1).
- R4: Any number of lanes that name the same address are served together in one pass (degree 1), for loads and for stores.
- R5: The reported degree equals the largest count of distinct addresses among active lanes mapped to one bank. A stride of 2 gives 2, a stride of 32 gives 32, and the padded column stride of 33 gives 1.
- R6: When several active lanes store to the same address, the word from the highest-numbered of them is the one kept.
- R7: `busy` is high from the cycle after acceptance for exactly degree+1 cycles. `done` is a single-cycle pulse in the first cycle with `busy` low, and `degree` and `rsp_rdata` are valid in that same cycle.
- R8: A request is accepted only while `busy` is low. A request presented while `busy` is high has no effect on the stored data.
- R9: A request with an all-zero mask completes with degree 0 after one busy cycle and changes no stored word.
- R10: After reset, `busy`, `done`, `degree` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mask | input | 32 | Active-lane mask, bit n = lane n |
| req_addr | input | 320 | Word address per lane, lane n at bits n*10 +: 10 |
| req_wdata | input | 1024 | Store word per lane, lane n at bits n*32 +: 32 |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| degree | output | 6 | Number of passes taken by the last access |
| rsp_rdata | output | 1024 | Load word per lane, lane n at bits n*32 +: 32 |

## Verification
The hardest case to reach from the ports is a request that arrives while the arbiter is still working through a long serialized access. It must be proven that such a request neither slips in nor corrupts storage. The stimulus first starts a 32-way column load at stride 32, which keeps the block busy for 33 cycles. During that window it holds a full-warp store of a marker pattern valid for several cycles and withdraws it before the completion cycle. It then reads the targeted words back and compares them with the untouched contents. Same-address store collisions, padded strides and random addresses crowded into four banks drive the degree count through its remaining cases.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } spad_op_e;
endpackage

// File: rtl/spad_bank_ram.sv
// One bank: synchronous write, synchronous read-before-write, no reset on the array.
module spad_bank_ram #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 32
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(ROWS)-1:0]  row,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/spad_bank_picker.sv
// For one bank: choose the row wanted by the lowest pending lane, serve every
// pending lane that wants that same row, and take the store word of the
// highest served lane.
module spad_bank_picker #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 10,
  parameter int BANK_W  = 5,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES*DATA_W-1:0] wdata,
  output logic [LANES-1:0]        serve,
  output logic                    active,
  output logic [ADDR_W-BANK_W-1:0] row,
  output logic [DATA_W-1:0]       wsel
);
  localparam int ROW_W = ADDR_W - BANK_W;
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [LANES-1:0] hit;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      hit[l] = pend[l] && (addr[l*ADDR_W +: BANK_W] == MY_BANK);
  end

  always_comb begin
    active = 1'b0;
    row    = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && !active) begin
        active = 1'b1;
        row    = addr[l*ADDR_W+BANK_W +: ROW_W];
      end
    end
  end

  always_comb begin
    wsel = '0;
    for (int l = 0; l < LANES; l++) begin
      serve[l] = hit[l] && (addr[l*ADDR_W+BANK_W +: ROW_W] == row);
      if (serve[l]) wsel = wdata[l*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/spad_conflict_arbiter.sv
module spad_conflict_arbiter
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [LANES-1:0]         req_mask,
  input  logic [LANES*ADDR_W-1:0]  req_addr,
  input  logic [LANES*DATA_W-1:0]  req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [CNT_W-1:0]         degree,
  output logic [LANES*DATA_W-1:0]  rsp_rdata
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;

  spad_op_e                op_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wdata_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES-1:0]        cap_lanes_q;
  logic                    cap_v_q;
  logic                    fin_q;
  logic [CNT_W-1:0]        pass_cnt_q;

  logic [LANES-1:0]  serve_b [BANKS];
  logic              act_b   [BANKS];
  logic [ROW_W-1:0]  row_b   [BANKS];
  logic [DATA_W-1:0] wd_b    [BANKS];
  logic [DATA_W-1:0] bank_q  [BANKS];

  logic [LANES-1:0] served;
  logic [LANES-1:0] left;
  logic             issue;
  logic             accept;

  assign accept = req_valid && !busy;
  assign issue  = busy && (pend_q != '0);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    spad_bank_picker #(
      .LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
      .DATA_W(DATA_W), .BANK_ID(b)
    ) u_pick (
      .pend  (pend_q),
      .addr  (addr_q),
      .wdata (wdata_q),
      .serve (serve_b[b]),
      .active(act_b[b]),
      .row   (row_b[b]),
      .wsel  (wd_b[b])
    );

    spad_bank_ram #(.DATA_W(DATA_W), .ROWS(ROWS)) u_ram (
      .clk  (clk),
      .en   (issue && act_b[b]),
      .we   (op_q == OP_STORE),
      .row  (row_b[b]),
      .wdata(wd_b[b]),
      .rdata(bank_q[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | serve_b[b];
    left = pend_q & ~served;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      degree      <= '0;
      rsp_rdata   <= '0;
      op_q        <= OP_LOAD;
      addr_q      <= '0;
      wdata_q     <= '0;
      pend_q      <= '0;
      cap_lanes_q <= '0;
      cap_v_q     <= 1'b0;
      fin_q       <= 1'b0;
      pass_cnt_q  <= '0;
    end else begin
      done        <= 1'b0;
      cap_v_q     <= issue;
      cap_lanes_q <= served;
      if (accept) begin
        busy       <= 1'b1;
        op_q       <= req_write ? OP_STORE : OP_LOAD;
        addr_q     <= req_addr;
        wdata_q    <= req_wdata;
        pend_q     <= req_mask;
        pass_cnt_q <= '0;
        rsp_rdata  <= '0;
        fin_q      <= (req_mask == '0);
      end else if (busy) begin
        if (issue) begin
          pend_q     <= left;
          pass_cnt_q <= pass_cnt_q + 1'b1;
          fin_q      <= (left == '0);
        end
        if (cap_v_q && op_q == OP_LOAD) begin
          for (int l = 0; l < LANES; l++)
            if (cap_lanes_q[l])
              rsp_rdata[l*DATA_W +: DATA_W] <= bank_q[addr_q[l*ADDR_W +: BANK_W]];
        end
        if (fin_q) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          degree <= pass_cnt_q;
          fin_q  <= 1'b0;
        end
      end
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: busy only drops together with the completion pulse
  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5: each pass serves only pending lanes and always makes progress
  assert_pass_progress_R5: assert property (@(posedge clk) disable iff (rst)
    issue |-> ((served & ~pend_q) == '0) && (served != '0));

  // R5: pass count never exceeds the lane count
  assert_pass_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> pass_cnt_q <= CNT_W'(LANES));

  // R8: the held request does not change while the access is in flight
  assert_busy_holds_req_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(addr_q) && $stable(op_q) && $stable(wdata_q)));
endmodule

// File: tb/spad_conflict_arbiter_tb.sv
`timescale 1ns/1ps
module spad_conflict_arbiter_tb;
  localparam int LANES = 32, ADDR_W = 10, DATA_W = 32, BANKS = 32, CNT_W = 6;
  localparam int WORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LANES-1:0]        req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*DATA_W-1:0] req_wdata = '0;
  logic busy, done;
  logic [CNT_W-1:0] degree;
  logic [LANES*DATA_W-1:0] rsp_rdata;

  always #2.5 clk = ~clk;

  spad_conflict_arbiter u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .degree(degree), .rsp_rdata(rsp_rdata));

  typedef struct {
    logic [LANES*DATA_W-1:0] data;
    int    deg;
    string dtag;
    string gtag;
  } exp_t;

  logic [DATA_W-1:0] model [WORDS];
  exp_t exp_q[$];
  int checks = 0, errors = 0, busy_run = 0;

  task automatic check(bit ok, string tag, string what,
                       logic [LANES*DATA_W-1:0] act, logic [LANES*DATA_W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [LANES*ADDR_W-1:0] stride(int base, int step);
    logic [LANES*ADDR_W-1:0] a;
    for (int l = 0; l < LANES; l++) a[l*ADDR_W +: ADDR_W] = ADDR_W'(base + l*step);
    return a;
  endfunction

  function automatic int deg_of(logic [LANES-1:0] m, logic [LANES*ADDR_W-1:0] a);
    int best = 0;
    for (int b = 0; b < BANKS; b++) begin
      int n = 0;
      for (int l = 0; l < LANES; l++) begin
        if (m[l] && (int'(a[l*ADDR_W +: ADDR_W]) % BANKS) == b) begin
          bit seen = 0;
          for (int j = 0; j < l; j++)
            if (m[j] && a[j*ADDR_W +: ADDR_W] == a[l*ADDR_W +: ADDR_W]) seen = 1;
          if (!seen) n++;
        end
      end
      if (n > best) best = n;
    end
    return best;
  endfunction

  // Driver: called at a falling edge with the block idle.
  task automatic launch(bit wr, logic [LANES-1:0] m, logic [LANES*ADDR_W-1:0] a,
                        logic [LANES*DATA_W-1:0] wd, string dtag, string gtag);
    exp_t e;
    e.data = '0;
    e.deg  = deg_of(m, a);
    e.dtag = dtag;
    e.gtag = gtag;
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) begin
        if (wr) model[a[l*ADDR_W +: ADDR_W]] = wd[l*DATA_W +: DATA_W];
        else    e.data[l*DATA_W +: DATA_W] = model[a[l*ADDR_W +: ADDR_W]];
      end
    end
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_mask = m; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_run++;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_rdata === e.data, e.dtag, "read data", rsp_rdata, e.data);
          check(int'(degree) == e.deg, e.gtag, "degree", degree, e.deg);
          check(busy_run == e.deg + 1, "R7", "busy length", busy_run, e.deg + 1);
        end
        busy_run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LANES*DATA_W-1:0] wd;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10", "busy", busy, 0);
    check(done == 1'b0, "R10", "done", done, 0);
    check(degree == '0, "R10", "degree", degree, 0);
    check(rsp_rdata == '0, "R10", "rdata", rsp_rdata, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1/R3: fill every word with stride-1 stores
    for (int k = 0; k < WORDS / LANES; k++) begin
      for (int l = 0; l < LANES; l++)
        wd[l*DATA_W +: DATA_W] = 32'h5A00_0000 ^ ((k*LANES + l) * 32'h0001_0103);
      launch(1'b1, '1, stride(k*LANES, 1), wd, "R2", "R3");
      wait_idle();
    end

    // R1/R3: stride-1 loads
    launch(1'b0, '1, stride(0, 1), '0, "R1", "R3"); wait_idle();
    launch(1'b0, '1, stride(512, 1), '0, "R1", "R3"); wait_idle();
    // R5: stride 2, stride 32, padded stride 33
    launch(1'b0, '1, stride(3, 2), '0, "R2", "R5"); wait_idle();
    launch(1'b0, '1, stride(1, 32), '0, "R2", "R5"); wait_idle();
    launch(1'b0, '1, stride(0, 33), '0, "R2", "R5"); wait_idle();
    // R4: broadcast of one address
    launch(1'b0, '1, stride(5, 0), '0, "R2", "R4"); wait_idle();
    // R5: two addresses in one bank
    begin
      logic [LANES*ADDR_W-1:0] a;
      for (int l = 0; l < LANES; l++) a[l*ADDR_W +: ADDR_W] = (l < 16) ? 10'd7 : 10'd39;
      launch(1'b0, '1, a, '0, "R2", "R5"); wait_idle();
    end
    // R2: partial mask, inactive lanes read zero
    launch(1'b0, 32'h0000_F0F1, stride(64, 32), '0, "R2", "R5"); wait_idle();
    // R6: all lanes store to one address, highest lane kept
    for (int l = 0; l < LANES; l++) wd[l*DATA_W +: DATA_W] = 32'hC000_0000 + l;
    launch(1'b1, '1, stride(100, 0), wd, "R2", "R4"); wait_idle();
    launch(1'b0, 32'h1, stride(100, 0), '0, "R6", "R4"); wait_idle();
    launch(1'b1, 32'h0000_03FF, stride(200, 0), wd, "R2", "R4"); wait_idle();
    launch(1'b0, 32'h3, stride(200, 0), '0, "R6", "R4"); wait_idle();
    // R9: empty mask
    launch(1'b1, '0, stride(0, 1), {LANES{32'hFFFF_FFFF}}, "R9", "R9"); wait_idle();
    launch(1'b0, '1, stride(0, 1), '0, "R9", "R3"); wait_idle();
    // R8: store presented while busy is ignored
    launch(1'b0, '1, stride(2, 32), '0, "R2", "R5");
    req_valid = 1'b1; req_write = 1'b1; req_mask = '1;
    req_addr = stride(32, 1); req_wdata = {LANES{32'hDEAD_BEEF}};
    repeat (5) @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    wait_idle();
    launch(1'b0, '1, stride(32, 1), '0, "R8", "R3"); wait_idle();
    // R5: random addresses crowded into four banks
    for (int t = 0; t < 24; t++) begin
      logic [LANES*ADDR_W-1:0] a;
      for (int l = 0; l < LANES; l++)
        a[l*ADDR_W +: ADDR_W] = ADDR_W'((($urandom % 8) << 5) | ($urandom % 4));
      launch(1'b0, LANES'($urandom) | 32'h1, a, '0, "R2", "R5");
      wait_idle();
    end

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule